// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a two-stage pipelined multiply-accumulate datapath for fixed-point filter loops. Each cycle it can accept one pair of signed 16-bit operands. It forms their 32-bit product in the first stage. In the second stage it either adds that product into a 40-bit accumulator or loads the product into the accumulator. The eight bits above the 32-bit product range act as guard bits, so long sums can grow before they overflow.

A per-operation saturation control chooses what happens when the 40-bit sum overflows. With saturation on, the sum clamps to the nearest 40-bit limit. With saturation off, the sum wraps. A sticky flag records that an overflow has happened.

The accumulator is presented two ways:
- as a pair of 32-bit words, low and high, so it can be stored into two adjacent registers;
- as a 32-bit result clamped to the signed 32-bit range, for writing back a finished filter output.

Top module: `sat_mac`

## Requirements
- R1: After reset, both accumulator words, the 32-bit readout and the overflow flag are all zero.
- R2: The operands are signed two's complement. The 32-bit product is sign-extended to 40 bits before it is added. A new operation may be issued on every clock cycle.
- R3: An operation whose valid input is high at rising edge k is visible on the outputs after rising edge k+1.
- R4: The low word carries accumulator bits 31:0. The high word carries accumulator bits 39:32 in its bits 7:0, sign-extended through bit 31.
- R5: With saturation enabled for an operation, a sum above 0x7F_FFFF_FFFF becomes 0x7F_FFFF_FFFF, and a sum below 0x80_0000_0000 (as a signed 40-bit value) becomes 0x80_0000_0000.
- R6: With saturation disabled, the sum wraps modulo 2^40.
- R7: The overflow flag goes high when an accumulate's 40-bit signed sum overflows, whether or not saturation is enabled. It then stays high until a clear operation or reset.
- R8: An operation with clear high loads the accumulator with its own product instead of adding it, and drops the overflow flag.
- R9: The 32-bit readout equals accumulator bits 31:0 when the accumulator lies within the signed 32-bit range. Otherwise it is 0x7FFF_FFFF for a positive accumulator and 0x8000_0000 for a negative one.
- R10: An operation with valid low leaves the accumulator and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation issue strobe |
| in_clear | input | 1 | Load the product instead of accumulating |
| in_sat | input | 1 | Saturate this operation on overflow |
| in_a | input | 16 | Signed multiplicand |
| in_b | input | 16 | Signed multiplier |
| acc_lo | output | 32 | Accumulator bits 31:0 (even word) |
| acc_hi | output | 32 | Accumulator bits 39:32, sign-extended (odd word) |
| acc_sat32 | output | 32 | Accumulator clamped to the signed 32-bit range |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default widths: 16-bit operands, a 40-bit accumulator and 32-bit words. At these widths, about 512 back-to-back full-scale products are enough to overflow the guard bits. That makes both saturation limits, wrap-around and the sticky flag reachable within a few thousand cycles. Directed runs of extreme operand pairs, including the negative-by-negative case, drive those limits. A long seeded random stream of mixed valid, clear and saturation settings then checks every output against a bench model on every cycle.

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_clear,
  input  logic                     in_sat,
  input  logic signed [OP_W-1:0]   in_a,
  input  logic signed [OP_W-1:0]   in_b,
  output logic [WORD_W-1:0]        acc_lo,
  output logic [WORD_W-1:0]        acc_hi,
  output logic [WORD_W-1:0]        acc_sat32,
  output logic                     ovf
);
  localparam int PROD_W = 2 * OP_W;
  localparam int HI_W   = ACC_W - WORD_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic                     v1, clr1, sat1;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      clr1 <= 1'b0;
      sat1 <= 1'b0;
      prod <= '0;
    end else begin
      v1   <= in_valid;
      clr1 <= in_clear;
      sat1 <= in_sat;
      prod <= in_a * in_b;
    end
  end

  logic [ACC_W-1:0] prod_ext, sum;
  logic             ov_pos, ov_neg;

  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign sum      = acc + prod_ext;
  assign ov_pos   = !acc[ACC_W-1] && !prod_ext[ACC_W-1] &&  sum[ACC_W-1];
  assign ov_neg   =  acc[ACC_W-1] &&  prod_ext[ACC_W-1] && !sum[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (v1) begin
      if (clr1) begin
        acc <= prod_ext;
        ovf <= 1'b0;
      end else begin
        if (sat1 && ov_pos)      acc <= ACC_MAX;
        else if (sat1 && ov_neg) acc <= ACC_MIN;
        else                     acc <= sum;
        if (ov_pos || ov_neg) ovf <= 1'b1;
      end
    end
  end

  logic fits32;
  assign fits32 = (acc[ACC_W-1:WORD_W-1] == '0) || (acc[ACC_W-1:WORD_W-1] == '1);

  assign acc_lo    = acc[WORD_W-1:0];
  assign acc_hi    = {{(2*WORD_W-ACC_W){acc[ACC_W-1]}}, acc[ACC_W-1:WORD_W]};
  assign acc_sat32 = fits32 ? acc[WORD_W-1:0]
                   : (acc[ACC_W-1] ? {1'b1, {(WORD_W-1){1'b0}}}
                                   : {1'b0, {(WORD_W-1){1'b1}}});

  // R5
  sat_pos_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !clr1 && sat1 && ov_pos) |=> (acc_hi[HI_W-1:0] == 8'h7F && acc_lo == '1));
  // R5
  sat_neg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !clr1 && sat1 && ov_neg) |=> (acc_hi[HI_W-1:0] == 8'h80 && acc_lo == '0));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(v1 && clr1)) |=> ovf);
  // R8
  clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && clr1) |=> (!ovf && acc_lo == $past(prod_ext[WORD_W-1:0])));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> ($stable(acc_lo) && $stable(acc_hi) && $stable(ovf)));
  // R9
  sat32_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hi == {WORD_W{acc_lo[WORD_W-1]}}) |-> (acc_sat32 == acc_lo));
endmodule

// File: tb/sat_mac_test.sv
module sat_mac_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_clear = 0, in_sat = 0;
  logic signed [15:0] in_a = 0, in_b = 0;
  logic [31:0] acc_lo, acc_hi, acc_sat32;
  logic ovf;

  always #2 clk = ~clk;

  sat_mac uut (.clk, .rst_n, .in_valid, .in_clear, .in_sat, .in_a, .in_b,
               .acc_lo, .acc_hi, .acc_sat32, .ovf);

  int checks = 0, errors = 0;
  string tag = "R2 R3";
  longint s1_acc = 0, s2_acc = 0;
  bit s1_ovf = 0, s2_ovf = 0;

  localparam longint AMAX = 64'sh7F_FFFF_FFFF;
  localparam longint AMIN = -64'sh80_0000_0000;

  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, got, exp);
    end
  endtask

  function automatic logic [31:0] sat32(longint v);
    if (v > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  task automatic step(bit v, bit c, bit s, logic signed [15:0] a, logic signed [15:0] b);
    longint p, n, sum;
    bit no;
    @(negedge clk);
    chk({tag, " R4 lo"}, acc_lo, s2_acc[31:0]);
    chk({tag, " R4 hi"}, acc_hi, s2_acc[63:32]);
    chk({tag, " R9"}, acc_sat32, sat32(s2_acc));
    chk({tag, " R7 ovf"}, {31'b0, ovf}, {31'b0, s2_ovf});
    p = longint'(a) * longint'(b);
    n = s1_acc; no = s1_ovf;
    if (v) begin
      if (c) begin n = p; no = 0; end
      else begin
        sum = s1_acc + p;
        if (sum > AMAX || sum < AMIN) begin
          no = 1;
          if (s) n = (sum > AMAX) ? AMAX : AMIN;
          else   n = longint'($signed(sum[39:0]));
        end else n = sum;
      end
    end
    s2_acc = s1_acc; s2_ovf = s1_ovf;
    s1_acc = n; s1_ovf = no;
    in_valid = v; in_clear = c; in_sat = s; in_a = a; in_b = b;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4337));
    repeat (3) @(negedge clk);
    chk("R1 lo", acc_lo, 0);
    chk("R1 hi", acc_hi, 0);
    chk("R1 sat32", acc_sat32, 0);
    chk("R1 ovf", {31'b0, ovf}, 0);
    rst_n = 1'b1;

    tag = "R8";
    step(1, 1, 0, 16'sd3, -16'sd5);
    tag = "R2 R3";
    step(1, 0, 0, -16'sd7, -16'sd9);
    step(1, 0, 0, 16'sd1000, -16'sd20000);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    tag = "R5 pos";
    step(1, 1, 1, 16'sh7FFF, 16'sh7FFF);
    for (int i = 0; i < 300; i++) step(1, 0, 1, 16'sh7FFF, 16'sh7FFF);
    for (int i = 0; i < 300; i++) step(1, 0, 1, -16'sh8000, -16'sh8000);
    tag = "R10";
    for (int i = 0; i < 5; i++) step(0, 0, 1, 16'sh7FFF, 16'sh7FFF);

    tag = "R5 neg";
    step(1, 1, 1, -16'sh8000, 16'sh7FFF);
    for (int i = 0; i < 600; i++) step(1, 0, 1, -16'sh8000, 16'sh7FFF);

    tag = "R6";
    step(1, 1, 0, -16'sh8000, -16'sh8000);
    for (int i = 0; i < 600; i++) step(1, 0, 0, -16'sh8000, -16'sh8000);
    for (int i = 0; i < 600; i++) step(1, 0, 0, -16'sh8000, 16'sh7FFF);

    tag = "R2 rand";
    for (int i = 0; i < 4000; i++) begin
      automatic logic [31:0] r = $urandom;
      automatic bit big = r[4];
      automatic logic signed [15:0] a = big ? {r[5], {15{~r[5]}}} : 16'($urandom);
      automatic logic signed [15:0] b = big ? {r[6], {15{~r[6]}}} : 16'($urandom);
      step(r[1:0] != 0, r[11:7] == 0, r[2], a, b);
    end

    tag = "R10 flush";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule